// File: doc/BRIEF.md
# Control FSM with Serial State Loading

This block is a small Moore control machine for a transfer sequencer. It has six named states, a four-symbol functional input alphabet and a four-bit control output. For diagnostics, one extra input symbol is added to its state table. That symbol is `set_en_i` high, and while it is applied the machine leaves its functional transitions. It then steps through the state graph of a three-bit shift register.

Each clock under the setting symbol moves the current code one place to the left and takes `ser_i` into the least significant bit. Any state code can therefore be forced in three clocks, most significant bit first, with no synchronizing sequence. The unused codes can be forced the same way. When the symbol is released, the machine carries on with functional transitions from the loaded state.

The outputs depend on the state only. The state code is also brought out, so a test run can confirm each loaded state and every transition.

Top module: `tfsm_shiftset`

States and codes: IDLE=0, ARM=1, LOAD=2, RUN=3, DRAIN=4, FAULT=5. Codes 6 and 7 are unused.

Symbols on `sym_i`: NOP=0, GO=1, ACK=2, ABORT=3.

Functional transitions:
- IDLE: GO goes to ARM.
- ARM: ACK goes to LOAD, ABORT goes to IDLE.
- LOAD: GO goes to RUN, ABORT goes to FAULT.
- RUN: ACK goes to DRAIN, ABORT goes to FAULT.
- DRAIN: ACK goes to IDLE, GO goes to LOAD, ABORT goes to FAULT.
- FAULT: ACK goes to IDLE.
- Any state: every other symbol holds the state.

## Requirements
- R1: While `rst_i` is high at a rising edge, the state becomes IDLE (code 0) and `ctl_o` becomes 0000. Reset wins over `set_en_i`.
- R2: With `rst_i` low and `set_en_i` high at an edge, the next code is {state[1:0], ser_i}, whatever `sym_i` holds.
- R3: Three setting clocks with the target bits applied MSB first leave `state_o` equal to the target, for each of the codes 0 to 7.
- R4: With `set_en_i` low, each of the six states follows the functional transitions listed above on each of the four symbols.
- R5: With `set_en_i` low, unused codes 6 and 7 go to IDLE on the next edge for every symbol.
- R6: `ctl_o` depends on the state only. Its bits are [0] busy, [1] load, [2] run and [3] error. The values are IDLE 0000, ARM 0001, LOAD 0011, RUN 0101, DRAIN 0111, FAULT 1000, and 1000 for the unused codes.
- R7: On the first edge after `set_en_i` falls, the transition is the functional one taken from the loaded state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sym_i | input | 2 | Functional input symbol |
| set_en_i | input | 1 | Applies the state-setting symbol |
| ser_i | input | 1 | Serial bit shifted into the state LSB |
| ctl_o | output | 4 | Moore control outputs |
| state_o | output | 3 | Current state code |

## Verification
The bench builds the block with its default sizes: six states, which gives a three-bit code and leaves codes 6 and 7 unused. The shift path can reach every one of the eight codes, so the unused codes can be forced and their recovery to IDLE observed. Each of the 32 pairs of loaded state and symbol is checked directly. A seeded random phase then mixes setting clocks, functional symbols and resets.

// File: rtl/tfsm_pkg.sv
`timescale 1ns/1ps
package tfsm_pkg;
    localparam int NUM_STATES = 6;
    localparam int STATE_W    = $clog2(NUM_STATES);
    localparam int SYM_W      = 2;
    localparam int CTL_W      = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_LOAD  = 3'd2,
        ST_RUN   = 3'd3,
        ST_DRAIN = 3'd4,
        ST_FAULT = 3'd5
    } state_e;

    typedef enum logic [SYM_W-1:0] {
        SY_NOP   = 2'd0,
        SY_GO    = 2'd1,
        SY_ACK   = 2'd2,
        SY_ABORT = 2'd3
    } sym_e;

    localparam state_e SAFE_STATE = ST_IDLE;

    localparam logic [CTL_W-1:0] CTL_IDLE  = 4'b0000;
    localparam logic [CTL_W-1:0] CTL_ARM   = 4'b0001;
    localparam logic [CTL_W-1:0] CTL_LOAD  = 4'b0011;
    localparam logic [CTL_W-1:0] CTL_RUN   = 4'b0101;
    localparam logic [CTL_W-1:0] CTL_DRAIN = 4'b0111;
    localparam logic [CTL_W-1:0] CTL_ERR   = 4'b1000;
endpackage

// File: rtl/tfsm_func_next.sv
`timescale 1ns/1ps
module tfsm_func_next
    import tfsm_pkg::*;
(
    input  logic [STATE_W-1:0] cur_i,
    input  logic [SYM_W-1:0]   sym_i,
    output logic [STATE_W-1:0] nxt_o
);
    state_e cur;
    sym_e   sym;
    state_e nxt;

    always_comb begin
        cur = state_e'(cur_i);
        sym = sym_e'(sym_i);
        nxt = SAFE_STATE;
        unique case (cur)
            ST_IDLE: begin
                if (sym == SY_GO) nxt = ST_ARM;
                else              nxt = ST_IDLE;
            end
            ST_ARM: begin
                unique case (sym)
                    SY_ACK:   nxt = ST_LOAD;
                    SY_ABORT: nxt = ST_IDLE;
                    default:  nxt = ST_ARM;
                endcase
            end
            ST_LOAD: begin
                unique case (sym)
                    SY_GO:    nxt = ST_RUN;
                    SY_ABORT: nxt = ST_FAULT;
                    default:  nxt = ST_LOAD;
                endcase
            end
            ST_RUN: begin
                unique case (sym)
                    SY_ACK:   nxt = ST_DRAIN;
                    SY_ABORT: nxt = ST_FAULT;
                    default:  nxt = ST_RUN;
                endcase
            end
            ST_DRAIN: begin
                unique case (sym)
                    SY_ACK:   nxt = ST_IDLE;
                    SY_GO:    nxt = ST_LOAD;
                    SY_ABORT: nxt = ST_FAULT;
                    default:  nxt = ST_DRAIN;
                endcase
            end
            ST_FAULT: begin
                if (sym == SY_ACK) nxt = ST_IDLE;
                else               nxt = ST_FAULT;
            end
            default: nxt = SAFE_STATE;
        endcase
        nxt_o = nxt;
    end
endmodule

// File: rtl/tfsm_shift_next.sv
`timescale 1ns/1ps
module tfsm_shift_next #(
    parameter int W = 3
) (
    input  logic [W-1:0] cur_i,
    input  logic         ser_i,
    output logic [W-1:0] nxt_o
);
    assign nxt_o[0] = ser_i;
    for (genvar i = 1; i < W; i++) begin : g_stage
        assign nxt_o[i] = cur_i[i-1];
    end
endmodule

// File: rtl/tfsm_out_dec.sv
`timescale 1ns/1ps
module tfsm_out_dec
    import tfsm_pkg::*;
(
    input  logic [STATE_W-1:0] cur_i,
    output logic [CTL_W-1:0]   ctl_o
);
    state_e cur;

    always_comb begin
        cur = state_e'(cur_i);
        unique case (cur)
            ST_IDLE:  ctl_o = CTL_IDLE;
            ST_ARM:   ctl_o = CTL_ARM;
            ST_LOAD:  ctl_o = CTL_LOAD;
            ST_RUN:   ctl_o = CTL_RUN;
            ST_DRAIN: ctl_o = CTL_DRAIN;
            ST_FAULT: ctl_o = CTL_ERR;
            default:  ctl_o = CTL_ERR;
        endcase
    end
endmodule

// File: rtl/tfsm_shiftset.sv
`timescale 1ns/1ps
module tfsm_shiftset
    import tfsm_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [SYM_W-1:0]   sym_i,
    input  logic               set_en_i,
    input  logic               ser_i,
    output logic [CTL_W-1:0]   ctl_o,
    output logic [STATE_W-1:0] state_o
);
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] func_nxt;
    logic [STATE_W-1:0] shift_nxt;

    tfsm_func_next i_func (
        .cur_i (state_q),
        .sym_i (sym_i),
        .nxt_o (func_nxt)
    );

    tfsm_shift_next #(.W(STATE_W)) i_shift (
        .cur_i (state_q),
        .ser_i (ser_i),
        .nxt_o (shift_nxt)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i)         state_q <= SAFE_STATE;
        else if (set_en_i) state_q <= shift_nxt;
        else               state_q <= func_nxt;
    end

    tfsm_out_dec i_out (
        .cur_i (state_q),
        .ctl_o (ctl_o)
    );

    assign state_o = state_q;
endmodule

// File: rtl/tfsm_shiftset_chk.sv
`timescale 1ns/1ps
module tfsm_shiftset_chk
    import tfsm_pkg::*;
(
    input logic               clk_i,
    input logic               rst_i,
    input logic [SYM_W-1:0]   sym_i,
    input logic               set_en_i,
    input logic               ser_i,
    input logic [CTL_W-1:0]   ctl_o,
    input logic [STATE_W-1:0] state_o
);
    AST_RESET_IDLE: assert property (@(posedge clk_i)
        rst_i |=> (state_o == '0)); // R1

    AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        set_en_i |=> (state_o == {$past(state_o[STATE_W-2:0]), $past(ser_i)})); // R2

    AST_UNUSED_SAFE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!set_en_i && (state_o >= STATE_W'(NUM_STATES))) |=> (state_o == '0)); // R5

    AST_NOP_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!set_en_i && (sym_i == SY_NOP) && (state_o < STATE_W'(NUM_STATES))) |=> $stable(state_o)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == '0) |-> (ctl_o == '0)); // R6

    AST_ERR_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        ctl_o[3] |-> (state_o >= STATE_W'(5))); // R6
endmodule

bind tfsm_shiftset tfsm_shiftset_chk i_chk (.*);

// File: tb/test_tfsm_shiftset.sv
`timescale 1ns/1ps
module test_tfsm_shiftset;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       set_en = 1'b1;
    logic       ser = 1'b1;
    logic [1:0] sym = 2'd0;
    logic [3:0] ctl;
    logic [2:0] st;
    logic [2:0] model;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tfsm_shiftset i_tfsm_shiftset (
        .clk_i    (clk),
        .rst_i    (rst),
        .sym_i    (sym),
        .set_en_i (set_en),
        .ser_i    (ser),
        .ctl_o    (ctl),
        .state_o  (st)
    );

    function automatic logic [2:0] ref_next(logic [2:0] s, logic [1:0] y);
        case (s)
            3'd0: return (y == 2'd1) ? 3'd1 : 3'd0;
            3'd1: return (y == 2'd2) ? 3'd2 : (y == 2'd3) ? 3'd0 : 3'd1;
            3'd2: return (y == 2'd1) ? 3'd3 : (y == 2'd3) ? 3'd5 : 3'd2;
            3'd3: return (y == 2'd2) ? 3'd4 : (y == 2'd3) ? 3'd5 : 3'd3;
            3'd4: return (y == 2'd2) ? 3'd0 : (y == 2'd1) ? 3'd2 :
                         (y == 2'd3) ? 3'd5 : 3'd4;
            3'd5: return (y == 2'd2) ? 3'd0 : 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [3:0] ref_out(logic [2:0] s);
        case (s)
            3'd0: return 4'b0000;
            3'd1: return 4'b0001;
            3'd2: return 4'b0011;
            3'd3: return 4'b0101;
            3'd4: return 4'b0111;
            default: return 4'b1000;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [2:0] exp_s);
        n_cmp++;
        if (st !== exp_s) begin
            n_bad++;
            $display("FAIL %s state: actual %0d expected %0d", req, st, exp_s);
        end
        n_cmp++;
        if (ctl !== ref_out(exp_s)) begin
            n_bad++;
            $display("FAIL R6 ctl in state %0d: actual %b expected %b", exp_s, ctl, ref_out(exp_s));
        end
    endtask

    task automatic load(logic [2:0] code);
        set_en = 1'b1;
        for (int i = 2; i >= 0; i--) begin
            ser = code[i];
            sym = 2'($urandom);
            tick();
            model = {model[1:0], code[i]};
            check("R2", model);
        end
        check("R3", code);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        model = 3'd0;
        // R1: reset held while the setting symbol shifts ones
        tick();
        tick();
        check("R1", 3'd0);
        rst = 1'b0;
        // R3: every code reached in three clocks
        for (int c = 0; c < 8; c++) load(3'(c));
        // R4 R5 R7: every loaded state against every symbol
        for (int c = 0; c < 8; c++) begin
            for (int y = 0; y < 4; y++) begin
                load(3'(c));
                set_en = 1'b0;
                sym = 2'(y);
                tick();
                model = ref_next(3'(c), 2'(y));
                check((c >= 6) ? "R5" : "R4/R7", model);
            end
        end
        // random mix, R1 R2 R4
        for (int k = 0; k < 400; k++) begin
            rst = (($urandom % 16) == 0);
            set_en = (($urandom % 4) == 0);
            ser = 1'($urandom);
            sym = 2'($urandom);
            tick();
            if (rst)         model = 3'd0;
            else if (set_en) model = {model[1:0], ser};
            else             model = ref_next(model, sym);
            check(rst ? "R1" : set_en ? "R2" : "R4", model);
        end
        rst = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R3 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule